// File: doc/BRIEF.md
# Two-Level Segmented Address Walker

The block turns a 32-bit virtual address into a physical address in two table lookups. It first reads one word from a segment table, whose location comes from a base input. That word gives the base of a per-segment page table. It then reads one word from that page table, which gives the base of the page. The physical address is the page base plus the in-page offset. If either entry is marked not present, the walk stops and a fault is reported in place of an address. Handling the fault, replacing pages and moving data are left to software.

The walker reaches memory through one request/response port. That memory is word-addressed, and its read data may arrive any number of cycles after the request is taken. Only one walk is in progress at a time. A write access that finds the page entry clean stores the entry back with its dirty bit set. This lets write-back paging later tell which pages must be copied out.

Both kinds of table entry have the same layout:
- bit 0 is the present flag.
- bit 1 is the dirty flag.
- bits 31:10 are the upper bits of the next base. Its low 10 bits are zero.

Top module: `seg_page_walker`

## Requirements
- R1: The virtual address splits into a segment number in bits 31:21, a page number in bits 20:10 and a displacement in bits 9:0. The first memory read goes to `seg_tbl_base` plus the segment number.
- R2: When the segment entry has bit 0 set, the second read goes to {segment entry[31:10], 10'b0} plus the page number.
- R3: When the page entry has bit 0 set, the response has `rsp_fault` low and `rsp_paddr` = {page entry[31:10], 10'b0} + displacement. Bits 9:0 of `rsp_paddr` equal the displacement.
- R4: A segment entry with bit 0 clear ends the walk with `rsp_fault` high and `rsp_fault_pg` low, with no page-table read.
- R5: A page entry with bit 0 clear ends the walk with `rsp_fault` high and `rsp_fault_pg` high, and no write is made.
- R6: A write access whose page entry has bit 1 clear issues one memory write, before the response, to the page-entry address. The written data is the entry with bit 1 set. A read access issues no write, and neither does a write access whose entry already has bit 1 set.
- R7: `req_ready` is high only while no walk is in progress. A `req_valid` seen while it is low starts no walk and does not change the response.
- R8: A memory request stays asserted, with unchanged address and direction, until `mem_req_ready` accepts it. The walker waits any number of cycles for `mem_rsp_valid`.
- R9: `rsp_valid` is a one-cycle pulse. It carries the requested virtual address on `rsp_vaddr`, and `rsp_paddr` is zero on a fault. `req_ready` is high in the next cycle.
- R10: After reset, `req_ready` is high and `rsp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_tbl_base | input | 32 | Word address of the segment table, sampled when a request is taken |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write (marks the page dirty) |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Result is a fault |
| rsp_fault_pg | output | 1 | Fault was at page level (low: segment level) |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_vaddr | output | 32 | Virtual address of the walk |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Word address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
Some properties hold in every cycle, and the assertions check these:
- a pending memory request stays stable while it waits;
- the response is a single pulse and is followed by idle;
- the virtual address is held during a walk;
- a returned physical address keeps the displacement;
- a writeback always carries both present and dirty.

The bench's scenarios are needed for the rest. They show that the right table words are read at the right addresses for each field combination. They also show which of the two levels a fault lands on, and that the dirty writeback happens once and not again on a later write to the same page. Finally, they show that requests arriving mid-walk are dropped.

// File: rtl/seg_page_walker.sv
module seg_page_walker #(
  parameter int SEG_W = 11,
  parameter int PG_W  = 11,
  parameter int OFF_W = 10,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] seg_tbl_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic          req_write,
  output logic          rsp_valid,
  output logic          rsp_fault,
  output logic          rsp_fault_pg,
  output logic [AW-1:0] rsp_paddr,
  output logic [AW-1:0] rsp_vaddr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [AW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data
);
  localparam int VA_W = SEG_W + PG_W + OFF_W;
  localparam int PRESENT = 0;
  localparam int DIRTY   = 1;
  localparam logic [AW-1:0] DIRTY_MASK = AW'(1) << DIRTY;

  typedef enum logic [2:0] {IDLE, READ_SEG, READ_PT, MARK_PT, DONE, FAULT} st_t;

  st_t           st;
  logic          issued, wr_q, flt_pg_q;
  logic [AW-1:0] va_q, tbase_q, nbase_q, entry_q, pa_q;

  wire [SEG_W-1:0] seg_f = va_q[VA_W-1 -: SEG_W];
  wire [PG_W-1:0]  pg_f  = va_q[OFF_W +: PG_W];
  wire [OFF_W-1:0] off_f = va_q[OFF_W-1:0];

  wire [AW-1:0] seg_addr = tbase_q + {{(AW-SEG_W){1'b0}}, seg_f};
  wire [AW-1:0] pt_addr  = nbase_q + {{(AW-PG_W){1'b0}}, pg_f};
  wire [AW-1:0] rd_base  = {mem_rsp_data[AW-1:OFF_W], {OFF_W{1'b0}}};
  wire          hs       = mem_req_valid && mem_req_ready;
  wire          got      = issued && mem_rsp_valid;

  assign req_ready     = (st == IDLE);
  assign rsp_valid     = (st == DONE) || (st == FAULT);
  assign rsp_fault     = (st == FAULT);
  assign rsp_fault_pg  = (st == FAULT) && flt_pg_q;
  assign rsp_paddr     = (st == DONE) ? pa_q : '0;
  assign rsp_vaddr     = va_q;
  assign mem_req_valid = ((st == READ_SEG) || (st == READ_PT) || (st == MARK_PT)) && !issued;
  assign mem_req_write = (st == MARK_PT);
  assign mem_req_addr  = (st == READ_SEG) ? seg_addr : pt_addr;
  assign mem_req_wdata = entry_q | DIRTY_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      issued   <= 1'b0;
      wr_q     <= 1'b0;
      flt_pg_q <= 1'b0;
      va_q     <= '0;
      tbase_q  <= '0;
      nbase_q  <= '0;
      entry_q  <= '0;
      pa_q     <= '0;
    end else begin
      if (hs) issued <= 1'b1;
      unique case (st)
        IDLE: if (req_valid) begin
          st      <= READ_SEG;
          issued  <= 1'b0;
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          tbase_q <= seg_tbl_base;
        end
        READ_SEG: if (got) begin
          issued <= 1'b0;
          if (!mem_rsp_data[PRESENT]) begin
            st       <= FAULT;
            flt_pg_q <= 1'b0;
          end else begin
            st      <= READ_PT;
            nbase_q <= rd_base;
          end
        end
        READ_PT: if (got) begin
          issued  <= 1'b0;
          entry_q <= mem_rsp_data;
          pa_q    <= rd_base + {{(AW-OFF_W){1'b0}}, off_f};
          if (!mem_rsp_data[PRESENT]) begin
            st       <= FAULT;
            flt_pg_q <= 1'b1;
          end else if (wr_q && !mem_rsp_data[DIRTY]) begin
            st <= MARK_PT;
          end else begin
            st <= DONE;
          end
        end
        MARK_PT: if (hs) st <= DONE;
        DONE:    st <= IDLE;
        FAULT:   st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R9
  AST_BUSY_HOLDS_VA: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(rsp_vaddr)); // R7
  AST_MARK_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[PRESENT] && mem_req_wdata[DIRTY]); // R6
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]); // R3
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_paddr == '0 && !mem_req_valid); // R9
endmodule

// File: tb/sim_seg_page_walker.sv
module sim_seg_page_walker;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] seg_tbl_base = 32'h0001_0000;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault, rsp_fault_pg;
  logic [31:0] rsp_paddr, rsp_vaddr;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  seg_page_walker u0 (.*);

  logic [31:0] mem [int unsigned];
  int stall = 0, lat = 1, wait_ctr = 0, pcnt = 0;
  logic pend = 1'b0;
  logic [31:0] paddr_q = '0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_a0 = '0, rd_a1 = '0, wr_a = '0, wr_d = '0;
  int checks = 0, fails = 0;

  assign mem_req_ready = (wait_ctr >= stall);

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) wait_ctr <= 0;
    else if (mem_req_valid) wait_ctr <= wait_ctr + 1;
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (pcnt <= 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= rd(paddr_q);
        pend <= 1'b0;
      end else pcnt <= pcnt - 1;
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr] = mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
        wr_a <= mem_req_addr;
        wr_d <= mem_req_wdata;
      end else begin
        pend <= 1'b1;
        pcnt <= lat;
        paddr_q <= mem_req_addr;
        if (rd_cnt == 0) rd_a0 <= mem_req_addr; else rd_a1 <= mem_req_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        flt;
    logic        pg;
    logic [31:0] pa;
    logic [31:0] seg_a;
    logic [31:0] pt_a;
    logic        wb;
    logic [31:0] wb_d;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{{11'd0,11'd0,10'd5},       1'b0,1'b0,1'b0,32'h0010_0005,32'h0001_0000,32'h0002_0000,1'b0,32'h0},
    '{{11'd0,11'd0,10'd1023},    1'b1,1'b0,1'b0,32'h0010_03FF,32'h0001_0000,32'h0002_0000,1'b1,32'h0010_0003},
    '{{11'd0,11'd0,10'd0},       1'b1,1'b0,1'b0,32'h0010_0000,32'h0001_0000,32'h0002_0000,1'b0,32'h0},
    '{{11'd0,11'd1,10'd512},     1'b1,1'b0,1'b0,32'h0010_0600,32'h0001_0000,32'h0002_0001,1'b0,32'h0},
    '{{11'd0,11'd2,10'd0},       1'b1,1'b1,1'b1,32'h0,        32'h0001_0000,32'h0002_0002,1'b0,32'h0},
    '{{11'd5,11'd2047,10'd17},   1'b0,1'b0,1'b0,32'h0020_0C11,32'h0001_0005,32'h0003_0BFF,1'b0,32'h0},
    '{{11'd2047,11'd3,10'd1023}, 1'b1,1'b0,1'b0,32'h00FF_FFFF,32'h0001_07FF,32'h0004_0003,1'b1,32'h00FF_FC03},
    '{{11'd7,11'd0,10'd0},       1'b1,1'b1,1'b0,32'h0,        32'h0001_0007,32'h0,        1'b0,32'h0},
    '{{11'd9,11'd4,10'd3},       1'b0,1'b1,1'b0,32'h0,        32'h0001_0009,32'h0,        1'b0,32'h0}
  };

  task automatic launch(input logic [31:0] va, input logic wr);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    for (int k = 0; k < 400 && !rsp_valid; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mem[32'h0001_0000] = 32'h0002_0001;
    mem[32'h0001_0005] = 32'h0003_0401;
    mem[32'h0001_07FF] = 32'h0004_0001;
    mem[32'h0001_0007] = 32'h0005_0002;
    mem[32'h0002_0000] = 32'h0010_0001;
    mem[32'h0002_0001] = 32'h0010_0403;
    mem[32'h0002_0002] = 32'h0010_0800;
    mem[32'h0003_0BFF] = 32'h0020_0C01;
    mem[32'h0004_0003] = 32'h00FF_FC01;

    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R10 reset state",
          {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      stall = i % 3;
      lat   = (i % 4) + 1;
      launch(VEC[i].va, VEC[i].wr);
      wait_rsp();
      check(rsp_valid, "R9 response seen", {31'd0, rsp_valid}, 32'h1);
      check(rsp_vaddr == VEC[i].va, "R9 vaddr echoed", rsp_vaddr, VEC[i].va);
      check(rsp_fault == VEC[i].flt, "R4/R5 fault flag", {31'd0, rsp_fault}, {31'd0, VEC[i].flt});
      if (VEC[i].flt)
        check(rsp_fault_pg == VEC[i].pg, VEC[i].pg ? "R5 page-level fault" : "R4 segment-level fault",
              {31'd0, rsp_fault_pg}, {31'd0, VEC[i].pg});
      check(rsp_paddr == VEC[i].pa, "R3 physical address", rsp_paddr, VEC[i].pa);
      check(rd_a0 == VEC[i].seg_a, "R1 segment entry address", rd_a0, VEC[i].seg_a);
      if (VEC[i].pt_a != 32'h0) begin
        check(rd_cnt == 2, "R2 two reads", rd_cnt, 2);
        check(rd_a1 == VEC[i].pt_a, "R2 page entry address", rd_a1, VEC[i].pt_a);
      end else
        check(rd_cnt == 1, "R4 no page read", rd_cnt, 1);
      check(wr_cnt == (VEC[i].wb ? 1 : 0), "R6 writeback count", wr_cnt, {31'd0, VEC[i].wb});
      if (VEC[i].wb) begin
        check(wr_a == VEC[i].pt_a, "R6 writeback address", wr_a, VEC[i].pt_a);
        check(wr_d == VEC[i].wb_d, "R6 writeback data", wr_d, VEC[i].wb_d);
      end
      @(negedge clk);
      check(!rsp_valid && req_ready, "R9 single pulse then idle",
            {30'd0, rsp_valid, req_ready}, 32'h1);
    end

    stall = 4; lat = 20;
    launch({11'd0, 11'd0, 10'd7}, 1'b0);
    req_vaddr = {11'd5, 11'd2047, 10'd1}; req_valid = 1'b1;
    @(negedge clk);
    check(!req_ready, "R7 busy during walk", {31'd0, req_ready}, 32'h0);
    wait_rsp();
    check(rsp_paddr == 32'h0010_0007, "R8 long latency result", rsp_paddr, 32'h0010_0007);
    check(rsp_vaddr == {11'd0, 11'd0, 10'd7}, "R7 busy request ignored", rsp_vaddr, {11'd0, 11'd0, 10'd7});
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    check(rd_cnt == 2 && !rsp_valid, "R7 no walk started by dropped request", rd_cnt, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule